// File: doc/BRIEF.md
# Sync-Edge Clock Phase Realigner

This controller sits beside the post divider of a clock generator and lets an external, asynchronous SYNC signal set the phase of the divided output clock. One SYNC edge (the inactive one) asks for the output clock to be parked. The controller waits for the divider to finish the output period it is in, then holds the divider. The opposite (active) edge releases the divider with a one-cycle counter-clear pulse, so the first new output period starts a fixed number of fast-clock cycles after that edge.

SYNC is sampled on both edges of the fast clock. For each restart the controller reports whether the active edge fell in the first or the second half of a fast-clock period. The divider can use this to delay its restart by half a cycle, which gives an alignment step of half a fast-clock period. An enable input turns the whole function off, and a polarity input chooses which SYNC edge is the active one. The divider gives the controller a marker in the last fast-clock cycle of each output period. The controller gives the divider a hold level, a clear pulse and the half-cycle flag. All pins are plain control signals; no data stream crosses the block.

Top module: `clk_phase_realign`

## Requirements
- R1: After reset, halt_o, clear_o and late_half_o are 0. SYNC transitions that reach the end of the synchronizer within the first STAGES+1 clock cycles after reset are ignored.
- R2: While sync_en is 0, SYNC is ignored. halt_o and clear_o are 0 from the cycle after sync_en is sampled low, even if the output was halted before.
- R3: The active edge is chosen by sync_pol. With sync_pol=1 a rising SYNC edge is active and a falling edge is inactive. With sync_pol=0 it is the other way round.
- R4: An inactive edge while the clock runs arms a stop. halt_o rises only in the cycle after the first period_end sampled high after arming, so no output period is cut short.
- R5: An active edge while halted gives a single clear_o pulse, and halt_o falls in the same cycle. The pulse appears on the STAGES+1-th rising clock edge after the first rising edge that follows the SYNC change (the 3rd with STAGES=2).
- R6: In the cycle where clear_o is 1, late_half_o is 0 if the active SYNC change came while clk was high (first half of the period). It is 1 if the change came while clk was low (second half).
- R7: An active edge that arrives while a stop is still draining is held. There is no halt, and clear_o pulses in the cycle after period_end is sampled. If period_end and the active edge are seen in the same cycle, the clear comes at once in the next cycle.
- R8: An active edge while the clock is running has no effect: clear_o and halt_o stay 0.
- R9: An inactive edge after a held restart cancels that restart. The block returns to draining and halts at the next period_end without a clear.
- R10: halt_o and clear_o are never 1 together, and clear_o is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (the divider's input clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Asynchronous SYNC input |
| sync_en | input | 1 | 1 = realign function on, 0 = SYNC ignored |
| sync_pol | input | 1 | 1 = rising edge active, 0 = falling edge active |
| period_end | input | 1 | From divider: high in the last fast-clock cycle of an output period |
| halt_o | output | 1 | Hold request to the post divider |
| clear_o | output | 1 | One-cycle counter-clear (restart) pulse to the post divider |
| late_half_o | output | 1 | Valid with clear_o: the active edge fell in the second half-period |

## Verification
A wrong sequencer state shows up at once at the divider pins. It can appear as a halt that starts before a period_end, a clear pulse with no halt or pending restart behind it, or a halt that never ends. Each of these shows within one or two cycles of the SYNC edge reaching the end of the synchronizer. A wrong synchronizer depth or a bad half-cycle snapshot shows up as a clear pulse one cycle early or late, or as a wrong late_half_o flag in the same cycle as the clear. The bench therefore checks the exact cycle of every clear, and drives SYNC in both halves of the clock period.

// File: rtl/realign_pkg.sv
package realign_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,  // divider running freely
    ST_DRAIN = 2'd1,  // stop armed, waiting for end of output period
    ST_HELD  = 2'd2,  // divider held
    ST_PEND  = 2'd3   // stop armed and restart already requested
  } realign_state_e;
endpackage

// File: rtl/realign_sampler.sv
module realign_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic lvl_rise,
  output logic lvl_fall,
  output logic first_half
);
  logic [STAGES-1:0] pos_chain;
  logic [STAGES-1:0] neg_chain;
  logic              pos_prev;
  logic              neg_snap;

  // rising-edge synchronizer chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_chain <= '0;
    end else begin
      pos_chain[0] <= sync_in;
      for (int i = 1; i < STAGES; i++) pos_chain[i] <= pos_chain[i-1];
    end
  end

  // falling-edge synchronizer chain, half a cycle ahead when SYNC moves while clk is high
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_chain <= '0;
    end else begin
      neg_chain[0] <= sync_in;
      for (int i = 1; i < STAGES; i++) neg_chain[i] <= neg_chain[i-1];
    end
  end

  // retime falling-edge result into the rising-edge domain, keep previous level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_prev <= 1'b0;
      neg_snap <= 1'b0;
    end else begin
      pos_prev <= pos_chain[STAGES-1];
      neg_snap <= neg_chain[STAGES-1];
    end
  end

  assign lvl_rise   = pos_chain[STAGES-1] & ~pos_prev;
  assign lvl_fall   = ~pos_chain[STAGES-1] & pos_prev;
  assign first_half = (neg_snap == pos_chain[STAGES-1]);
endmodule

// File: rtl/realign_qual.sv
module realign_qual #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_rise,
  input  logic lvl_fall,
  input  logic first_half,
  input  logic sync_en,
  input  logic sync_pol,
  output logic go_ev,
  output logic stop_ev,
  output logic go_late
);
  localparam int WARM = STAGES + 1;
  localparam int CW   = $clog2(WARM + 1);

  logic [CW-1:0] warm_cnt;
  logic          ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_cnt <= '0;
    end else if (!ready) begin
      warm_cnt <= warm_cnt + CW'(1);
    end
  end

  assign ready   = (warm_cnt == CW'(WARM));
  assign go_ev   = ready & sync_en & (sync_pol ? lvl_rise : lvl_fall);
  assign stop_ev = ready & sync_en & (sync_pol ? lvl_fall : lvl_rise);
  assign go_late = ~first_half;

  // R1
  warm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_cnt < CW'(WARM)) |-> !(go_ev || stop_ev));
endmodule

// File: rtl/realign_seq.sv
module realign_seq
  import realign_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_en,
  input  logic go_ev,
  input  logic stop_ev,
  input  logic go_late,
  input  logic period_end,
  output logic halt_o,
  output logic clear_o,
  output logic late_o
);
  realign_state_e state_q, state_d;
  logic           clear_q, restart, capture, late_q;

  always_comb begin
    state_d = state_q;
    restart = 1'b0;
    if (!sync_en) begin
      state_d = ST_RUN;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (stop_ev) state_d = ST_DRAIN;
        end
        ST_DRAIN: begin
          if (period_end) begin
            if (go_ev) begin
              restart = 1'b1;
              state_d = ST_RUN;
            end else begin
              state_d = ST_HELD;
            end
          end else if (go_ev) begin
            state_d = ST_PEND;
          end
        end
        ST_HELD: begin
          if (go_ev) begin
            restart = 1'b1;
            state_d = ST_RUN;
          end
        end
        ST_PEND: begin
          if (period_end) begin
            if (stop_ev) begin
              state_d = ST_HELD;
            end else begin
              restart = 1'b1;
              state_d = ST_RUN;
            end
          end else if (stop_ev) begin
            state_d = ST_DRAIN;
          end
        end
        default: state_d = ST_RUN;
      endcase
    end
  end

  assign capture = sync_en && go_ev && (state_q != ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      clear_q <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      clear_q <= restart;
      if (capture) late_q <= go_late;
    end
  end

  assign halt_o  = (state_q == ST_HELD);
  assign clear_o = clear_q;
  assign late_o  = late_q;

  // R10
  clear_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_o |=> !clear_o);
  // R10
  halt_clear_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_o && clear_o));
  // R4
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_o) |-> $past(period_end));
  // R2
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |=> (!halt_o && !clear_o));
  // R5
  halt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_o) |-> (clear_o || $past(!sync_en)));
endmodule

// File: rtl/clk_phase_realign.sv
module clk_phase_realign #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic sync_en,
  input  logic sync_pol,
  input  logic period_end,
  output logic halt_o,
  output logic clear_o,
  output logic late_half_o
);
  logic lvl_rise, lvl_fall, first_half;
  logic go_ev, stop_ev, go_late;

  realign_sampler #(.STAGES(STAGES)) sampler_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_in    (sync_in),
    .lvl_rise   (lvl_rise),
    .lvl_fall   (lvl_fall),
    .first_half (first_half)
  );

  realign_qual #(.STAGES(STAGES)) qual_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_rise   (lvl_rise),
    .lvl_fall   (lvl_fall),
    .first_half (first_half),
    .sync_en    (sync_en),
    .sync_pol   (sync_pol),
    .go_ev      (go_ev),
    .stop_ev    (stop_ev),
    .go_late    (go_late)
  );

  realign_seq seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_en    (sync_en),
    .go_ev      (go_ev),
    .stop_ev    (stop_ev),
    .go_late    (go_late),
    .period_end (period_end),
    .halt_o     (halt_o),
    .clear_o    (clear_o),
    .late_o     (late_half_o)
  );
endmodule

// File: tb/clk_phase_realign_tb_top.sv
module clk_phase_realign_tb_top;
  localparam int STAGES = 2;
  localparam int LAT    = STAGES + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_in = 1'b1, sync_en = 1'b1, sync_pol = 1'b0, period_end = 1'b0;
  logic halt, clear, late;
  int   n_vec = 0, n_bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  clk_phase_realign #(.STAGES(STAGES)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_en(sync_en),
    .sync_pol(sync_pol), .period_end(period_end),
    .halt_o(halt), .clear_o(clear), .late_half_o(late)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  // sample point: 12 ns after a rising edge (clk low, inputs settled)
  task automatic step();
    @(posedge clk);
    #12;
  endtask

  // change SYNC inside the next clock period: half 0 = clk high, half 1 = clk low
  task automatic drive_sync(input logic val, input bit half);
    @(posedge clk);
    #(half ? 15 : 5);
    sync_in = val;
  endtask

  function automatic logic act_lvl();
    return sync_pol;
  endfunction

  task automatic setup(input logic pol);
    sync_en = 1'b0;
    step();
    sync_pol = pol;
    sync_in  = pol;
    repeat (LAT + 1) step();
    sync_en = 1'b1;
    step();
  endtask

  task automatic do_stop(input bit half, input int gap);
    drive_sync(~act_lvl(), half);
    repeat (LAT + gap) begin
      step();
      chk("R4 no halt before period end", halt, 1'b0);
      chk("R10 no clear while draining", clear, 1'b0);
    end
    period_end = 1'b1;
    step();
    period_end = 1'b0;
    chk(sync_pol ? "R4 halt after period end" : "R3 halt after falling-active stop", halt, 1'b1);
  endtask

  task automatic do_go(input bit half);
    drive_sync(act_lvl(), half);
    repeat (LAT - 1) begin
      step();
      chk("R5 clear not early", clear, 1'b0);
      chk("R5 still halted", halt, 1'b1);
    end
    step();
    chk("R5 clear on time", clear, 1'b1);
    chk("R5 halt released", halt, 1'b0);
    chk("R6 half flag", late, logic'(half));
    step();
    chk("R10 single clear", clear, 1'b0);
    chk("R5 stays running", halt, 1'b0);
  endtask

  task automatic do_pend(input bit h1, input bit h2);
    drive_sync(~act_lvl(), h1);
    drive_sync(act_lvl(), h2);
    repeat (LAT) begin
      step();
      chk("R7 no halt when pending", halt, 1'b0);
      chk("R7 no clear before period end", clear, 1'b0);
    end
    period_end = 1'b1;
    step();
    period_end = 1'b0;
    chk("R7 pending clear", clear, 1'b1);
    chk("R7 never halted", halt, 1'b0);
    chk("R6 pending half flag", late, logic'(h2));
    step();
    chk("R10 single clear after pending", clear, 1'b0);
  endtask

  task automatic do_same(input bit h1, input bit h2);
    drive_sync(~act_lvl(), h1);
    drive_sync(act_lvl(), h2);
    repeat (LAT - 1) begin
      step();
      chk("R7 no clear yet", clear, 1'b0);
    end
    period_end = 1'b1;
    step();
    period_end = 1'b0;
    chk("R7 same-cycle clear", clear, 1'b1);
    chk("R7 same-cycle no halt", halt, 1'b0);
    chk("R6 same-cycle half flag", late, logic'(h2));
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset values, and SYNC high at reset exit with pol=0 must not arm a stop
    #25;
    chk("R1 reset halt", halt, 1'b0);
    chk("R1 reset clear", clear, 1'b0);
    chk("R1 reset flag", late, 1'b0);
    #10 rst_n = 1'b1;
    period_end = 1'b1;
    repeat (LAT + 3) begin
      step();
      chk("R1 warm-up edge ignored", halt, 1'b0);
      chk("R1 warm-up no clear", clear, 1'b0);
    end
    period_end = 1'b0;

    // basic stop/restart, both halves
    setup(1'b1);
    do_stop(1'b0, 0);
    do_go(1'b0);
    do_stop(1'b1, 3);
    do_go(1'b1);

    // R3: falling edge active
    setup(1'b0);
    do_stop(1'b0, 2);
    do_go(1'b1);

    // R7: held restart
    setup(1'b1);
    do_pend(1'b0, 1'b1);
    do_same(1'b1, 1'b0);

    // R9: cancel of a held restart
    setup(1'b0);
    drive_sync(~act_lvl(), 1'b0);
    repeat (3) begin step(); chk("R9 no clear", clear, 1'b0); end
    drive_sync(act_lvl(), 1'b1);
    repeat (3) begin step(); chk("R9 no clear", clear, 1'b0); end
    drive_sync(~act_lvl(), 1'b0);
    repeat (LAT) begin
      step();
      chk("R9 no halt yet", halt, 1'b0);
      chk("R9 no clear", clear, 1'b0);
    end
    period_end = 1'b1;
    step();
    period_end = 1'b0;
    chk("R9 halted after cancel", halt, 1'b1);
    chk("R9 no clear after cancel", clear, 1'b0);
    do_go(1'b0);

    // R8: active edge while running
    sync_en = 1'b0;
    step();
    sync_in = ~act_lvl();
    repeat (LAT + 1) step();
    sync_en = 1'b1;
    step();
    drive_sync(act_lvl(), 1'b0);
    repeat (LAT + 2) begin
      step();
      chk("R8 active edge ignored: clear", clear, 1'b0);
      chk("R8 active edge ignored: halt", halt, 1'b0);
    end

    // R2: disable releases a halt and ignores SYNC
    setup(1'b1);
    do_stop(1'b1, 1);
    sync_en = 1'b0;
    step();
    chk("R2 disable releases halt", halt, 1'b0);
    period_end = 1'b1;
    drive_sync(act_lvl(), 1'b0);
    repeat (LAT + 1) step();
    drive_sync(~act_lvl(), 1'b1);
    repeat (LAT + 2) begin
      step();
      chk("R2 ignored: halt", halt, 1'b0);
      chk("R2 ignored: clear", clear, 1'b0);
    end
    period_end = 1'b0;

    // constrained random sequences
    for (int i = 0; i < 30; i++) begin
      setup(logic'($urandom_range(0, 1)));
      case ($urandom_range(0, 2))
        0: begin
          do_stop(bit'($urandom_range(0, 1)), int'($urandom_range(0, 4)));
          do_go(bit'($urandom_range(0, 1)));
        end
        1: do_pend(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
        default: do_same(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule